// File: doc/BRIEF.md
# Tagged Ethernet Transmit Framer

This block turns a short message, delivered one byte per beat on a ready/valid stream, into a complete Ethernet frame stream for the MAC/PHY side. It sends the preamble and start delimiter first. It then sends the destination and source addresses, an optional 802.1Q tag and the type field. The payload passes through next, followed by zero padding up to the minimum frame size and a CRC-32 frame check sequence. It then holds the line idle for the inter-frame gap before it starts the next frame.

Configuration inputs set the addresses, the type value and whether a tag is inserted. When a tag is inserted, they also set the priority, the drop-eligible flag and the VLAN ID that go into it. The block samples all configuration at the moment a frame starts. The minimum payload depends on the tag mode, so a minimal frame always spans 64 bytes from the destination address through the check sequence. Counting the preamble and the gap, it takes 84 byte times on the wire.

Payloads longer than the maximum are cut to the maximum. The extra bytes are still taken from the input and thrown away, and an error flag is raised for that frame.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and after it is released with no input offered, out_valid, in_ready and out_err are all low.
- R2: Every frame begins with seven bytes of 0x55 followed by one byte of 0xD5.
- R3: After the start byte come the 6 destination address bytes, then the 6 source address bytes, each sent most significant byte first, and then the 2-byte type field sent most significant byte first.
- R4: With tagging enabled, four bytes are inserted between the source address and the type field: 0x81, 0x00, then {priority[2:0], drop_eligible, vid[11:8]}, then vid[7:0].
- R5: A payload shorter than the minimum for the active mode (46 bytes untagged, 42 bytes tagged) is followed by zero bytes up to that minimum, so the frame from the destination address through the check sequence is exactly 64 bytes. A payload at or above the minimum gets no padding.
- R6: The last four bytes are the complemented reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) over everything from the destination address through the padding, sent least significant byte first. out_last is high on the final one of these bytes only.
- R7: Only the first 1500 payload bytes of a longer message are sent. The remaining bytes up to in_last are accepted and dropped, and out_err is high on the final byte of that frame. out_err is low for a frame of 1500 bytes or fewer, including one that follows a truncated frame.
- R8: After the final check byte is accepted, out_valid and in_ready stay low for exactly 12 cycles when the next message is already waiting, and for at least 12 cycles in every case.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold their values. Stalls on either side and gaps in in_valid do not change the byte sequence.
- R10: Configuration is sampled when a frame starts. Changing it during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tag_en | input | 1 | Insert the 802.1Q tag |
| cfg_pcp | input | 3 | Tag priority |
| cfg_dei | input | 1 | Tag drop-eligible flag |
| cfg_vid | input | 12 | Tag VLAN ID |
| cfg_dst | input | 48 | Destination address |
| cfg_src | input | 48 | Source address |
| cfg_etype | input | 16 | Type field |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_last | input | 1 | Offered byte is the last of the message |
| in_ready | output | 1 | Payload byte taken this cycle |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_last | output | 1 | Final check sequence byte |
| out_ready | input | 1 | Downstream takes the byte |
| out_err | output | 1 | Current frame was truncated |

## Verification
A byte counter or phase that goes wrong shows up at the ports within the same frame. The bench compares each region of the frame separately: preamble, header, payload with padding, and check sequence. A misplaced boundary is therefore reported against the requirement whose region it breaks, and a corrupted CRC shows up in the last four bytes. A wrong gap count shows up as a low period other than 12 cycles, or as in_ready rising inside it. A configuration register that is not latched at frame start shows up in the header of the same frame. Stalls and bubbles are mixed with these frames, so any loss or duplication of state under backpressure changes bytes within one frame.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } txf_state_e;

  typedef struct packed {
    logic        tag_en;
    logic [2:0]  pcp;
    logic        dei;
    logic [11:0] vid;
    logic [47:0] dst;
    logic [47:0] src;
    logic [15:0] etype;
  } txf_cfg_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte of the reflected CRC-32 update, low bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_txf_crc.sv
module eth_txf_crc
  import eth_txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc32_step(crc_q, din);
    end
  end

  // R6: the register is loaded with all ones on a frame start.
  assert_crc_seed_R6: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/eth_txf_hdr.sv
module eth_txf_hdr
  import eth_txf_pkg::*;
#(
  parameter int          LENW     = 5,
  parameter logic [15:0] TAG_TPID = 16'h8100
) (
  input  txf_cfg_t        cfg,
  input  logic [LENW-1:0] idx,
  output logic [7:0]      byte_o,
  output logic [LENW-1:0] hdr_len
);

  localparam int ADDR_BYTES = 6;
  localparam int BASE_LEN   = 2 * ADDR_BYTES + 2;
  localparam int TAG_BYTES  = 4;

  logic [15:0] tci;
  int          i;

  assign tci     = {cfg.pcp, cfg.dei, cfg.vid};
  assign hdr_len = cfg.tag_en ? LENW'(BASE_LEN + TAG_BYTES) : LENW'(BASE_LEN);

  always_comb begin
    i      = int'(idx);
    byte_o = 8'h00;
    if (i < ADDR_BYTES) begin
      byte_o = cfg.dst[8*(ADDR_BYTES-1-i) +: 8];
    end else if (i < 2*ADDR_BYTES) begin
      byte_o = cfg.src[8*(2*ADDR_BYTES-1-i) +: 8];
    end else if (cfg.tag_en) begin
      case (i - 2*ADDR_BYTES)
        0:       byte_o = TAG_TPID[15:8];
        1:       byte_o = TAG_TPID[7:0];
        2:       byte_o = tci[15:8];
        3:       byte_o = tci[7:0];
        4:       byte_o = cfg.etype[15:8];
        default: byte_o = cfg.etype[7:0];
      endcase
    end else begin
      byte_o = (i == 2*ADDR_BYTES) ? cfg.etype[15:8] : cfg.etype[7:0];
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_txf_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1500,
  parameter int MIN_FRAME   = 64,
  parameter int PRE_LEN     = 8,
  parameter int GAP_LEN     = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_tag_en,
  input  logic [2:0]  cfg_pcp,
  input  logic        cfg_dei,
  input  logic [11:0] cfg_vid,
  input  logic [47:0] cfg_dst,
  input  logic [47:0] cfg_src,
  input  logic [15:0] cfg_etype,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  input  logic        out_ready,
  output logic        out_err
);

  localparam int FCS_LEN = 4;
  localparam int HDR_MAX = 18;
  localparam int CNTW    = $clog2(((PRE_LEN > HDR_MAX) ? PRE_LEN : HDR_MAX) + 1);
  localparam int PAYW    = $clog2(MAX_PAYLOAD + 1);
  localparam int GAPW    = $clog2(GAP_LEN + 1);
  localparam int FRW     = $clog2(PRE_LEN + HDR_MAX + MAX_PAYLOAD + FCS_LEN + 1);
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  txf_state_e      st_q;
  txf_cfg_t        cfg_q, cfg_in;
  logic [CNTW-1:0] cnt_q;
  logic [PAYW-1:0] pay_q, pay_next, min_pay;
  logic [GAPW-1:0] gap_q;
  logic [7:0]      od_q;
  logic            ov_q, ol_q, err_q;

  logic            adv, gap_done, start_ok, take, keep;
  logic [7:0]      hdr_byte, fcs_byte;
  logic [CNTW-1:0] hdr_len;
  logic [31:0]     crc_q, fcs_word;
  logic            crc_init, crc_en;
  logic [7:0]      crc_d;

  assign cfg_in = '{tag_en: cfg_tag_en, pcp: cfg_pcp, dei: cfg_dei, vid: cfg_vid,
                    dst: cfg_dst, src: cfg_src, etype: cfg_etype};

  eth_txf_hdr #(.LENW(CNTW)) u_hdr (
    .cfg     (cfg_q),
    .idx     (cnt_q),
    .byte_o  (hdr_byte),
    .hdr_len (hdr_len)
  );

  eth_txf_crc u_crc (
    .clk   (clk),
    .rst   (rst),
    .init  (crc_init),
    .en    (crc_en),
    .din   (crc_d),
    .crc_q (crc_q)
  );

  // Handshake and phase decode.
  assign adv      = !ov_q || out_ready;
  assign gap_done = (st_q == ST_GAP) && !ov_q && (gap_q == GAPW'(GAP_LEN - 1));
  assign start_ok = ((st_q == ST_IDLE) || gap_done) && in_valid;
  assign in_ready = (st_q == ST_PAY) && adv;
  assign take     = in_ready && in_valid;
  assign keep     = (pay_q < PAYW'(MAX_PAYLOAD));
  assign pay_next = keep ? pay_q + 1'b1 : pay_q;
  assign min_pay  = PAYW'(MIN_FRAME - FCS_LEN) - PAYW'(hdr_len);
  assign fcs_word = ~crc_q;
  assign fcs_byte = fcs_word[{cnt_q[1:0], 3'b000} +: 8];

  assign crc_init = adv && start_ok;
  assign crc_en   = adv && ((st_q == ST_HDR) || (st_q == ST_PAD) ||
                            ((st_q == ST_PAY) && take && keep));
  assign crc_d    = (st_q == ST_HDR) ? hdr_byte :
                    (st_q == ST_PAY) ? in_data  : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
      cnt_q <= '0;
      pay_q <= '0;
      gap_q <= '0;
      od_q  <= '0;
      ov_q  <= 1'b0;
      ol_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (adv) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      if (start_ok) begin
        cfg_q <= cfg_in;
        od_q  <= PRE_BYTE;
        ov_q  <= 1'b1;
        cnt_q <= CNTW'(1);
        pay_q <= '0;
        gap_q <= '0;
        err_q <= 1'b0;
        st_q  <= ST_PRE;
      end else begin
        case (st_q)
          ST_PRE: begin
            ov_q <= 1'b1;
            if (cnt_q == CNTW'(PRE_LEN - 1)) begin
              od_q  <= SFD_BYTE;
              cnt_q <= '0;
              st_q  <= ST_HDR;
            end else begin
              od_q  <= PRE_BYTE;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HDR: begin
            od_q <= hdr_byte;
            ov_q <= 1'b1;
            if (cnt_q == hdr_len - 1'b1) begin
              cnt_q <= '0;
              st_q  <= ST_PAY;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAY: begin
            if (in_valid) begin
              if (keep) begin
                od_q <= in_data;
                ov_q <= 1'b1;
              end else begin
                err_q <= 1'b1;
              end
              pay_q <= pay_next;
              if (in_last) begin
                cnt_q <= '0;
                st_q  <= (pay_next < min_pay) ? ST_PAD : ST_FCS;
              end
            end
          end
          ST_PAD: begin
            od_q  <= 8'h00;
            ov_q  <= 1'b1;
            pay_q <= pay_q + 1'b1;
            if (pay_q + 1'b1 == min_pay) begin
              st_q <= ST_FCS;
            end
          end
          ST_FCS: begin
            od_q <= fcs_byte;
            ov_q <= 1'b1;
            if (cnt_q == CNTW'(FCS_LEN - 1)) begin
              ol_q  <= 1'b1;
              gap_q <= '0;
              st_q  <= ST_GAP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_GAP: begin
            if (!ov_q) begin
              if (gap_done) begin
                st_q <= ST_IDLE;
              end else begin
                gap_q <= gap_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out_data  = od_q;
  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_err   = err_q;

  // Observation counters used only by the assertions below.
  logic [FRW-1:0]  chk_bytes;
  logic [GAPW-1:0] chk_low;
  logic            chk_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_bytes <= '0;
      chk_low   <= '0;
      chk_armed <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        chk_bytes <= out_last ? '0 : chk_bytes + 1'b1;
      end
      if (out_valid && out_ready && out_last) begin
        chk_armed <= 1'b1;
        chk_low   <= '0;
      end else if (out_valid) begin
        chk_armed <= 1'b0;
      end else if (chk_low != GAPW'(GAP_LEN)) begin
        chk_low <= chk_low + 1'b1;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_gap_start_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_gap_len_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && out_valid) |-> (chk_low == GAPW'(GAP_LEN)));

  assert_no_take_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> !in_ready);

  assert_min_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (chk_bytes + 1'b1 >= FRW'(PRE_LEN + MIN_FRAME)));

  assert_pay_cap_R7: assert property (@(posedge clk) disable iff (rst)
    pay_q <= PAYW'(MAX_PAYLOAD));

endmodule

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

  logic        clk, rst;
  logic        cfg_tag_en, cfg_dei;
  logic [2:0]  cfg_pcp;
  logic [11:0] cfg_vid;
  logic [47:0] cfg_dst, cfg_src;
  logic [15:0] cfg_etype;
  logic [7:0]  in_data, out_data;
  logic        in_valid, in_last, in_ready, out_valid, out_last, out_ready, out_err;

  eth_tx_framer u_dut (
    .clk(clk), .rst(rst), .cfg_tag_en(cfg_tag_en), .cfg_pcp(cfg_pcp), .cfg_dei(cfg_dei),
    .cfg_vid(cfg_vid), .cfg_dst(cfg_dst), .cfg_src(cfg_src), .cfg_etype(cfg_etype),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .out_err(out_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0] rxq[$];
  logic [7:0] fr[$];
  logic [7:0] expq[$];
  int         lenq[$];
  bit         errq[$];
  int         frames_done = 0;
  int         fr_cnt = 0;
  int         gap_cnt = 0;
  int         last_gap = -1;
  bit         armed = 0;
  bit         gap_rdy_bad = 0;
  bit         hold_bad = 0;
  bit         bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit         prev_v = 0, prev_r = 0, prev_l = 0;
  logic [7:0] prev_d = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Downstream model: picks out_ready, records accepted bytes, measures gaps.
  always @(negedge clk) begin
    if (rst) begin
      out_ready = 1'b1;
    end else begin
      if (prev_v && !prev_r && !(out_valid && out_data == prev_d && out_last == prev_l))
        hold_bad = 1;
      if (bp_en) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[3];
      end else begin
        out_ready = 1'b1;
      end
      if (armed && !out_valid) begin
        gap_cnt++;
        if (in_ready) gap_rdy_bad = 1;
      end
      if (armed && out_valid) begin
        last_gap = gap_cnt;
        armed = 0;
      end
      if (out_valid && out_ready) begin
        rxq.push_back(out_data);
        fr_cnt++;
        if (out_last) begin
          errq.push_back(out_err);
          lenq.push_back(fr_cnt);
          fr_cnt = 0;
          frames_done++;
          armed = 1;
          gap_cnt = 0;
        end
      end
      prev_v = out_valid;
      prev_r = out_ready;
      prev_d = out_data;
      prev_l = out_last;
    end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 13 + seed * 29 + (i >> 8)) & 255);
  endfunction

  task automatic set_cfg(input bit tag, input logic [2:0] pcp, input bit dei, input logic [11:0] vid);
    cfg_tag_en = tag;
    cfg_pcp    = pcp;
    cfg_dei    = dei;
    cfg_vid    = vid;
    cfg_dst    = 48'h0A1B_2C3D_4E5F;
    cfg_src    = 48'h0211_2233_4455;
    cfg_etype  = 16'h88B5;
  endtask

  // Expected frame from the requirements (R2-R7).
  task automatic build(input int n, input int seed, input bit tag, input logic [2:0] pcp,
                       input bit dei, input logic [11:0] vid);
    logic [7:0]  b[$];
    logic [31:0] c;
    int          kept, minp;
    expq.delete();
    for (int k = 0; k < 7; k++) expq.push_back(8'h55);
    expq.push_back(8'hD5);
    for (int k = 5; k >= 0; k--) b.push_back(cfg_dst[8*k +: 8]);
    for (int k = 5; k >= 0; k--) b.push_back(cfg_src[8*k +: 8]);
    if (tag) begin
      b.push_back(8'h81);
      b.push_back(8'h00);
      b.push_back({pcp, dei, vid[11:8]});
      b.push_back(vid[7:0]);
    end
    b.push_back(cfg_etype[15:8]);
    b.push_back(cfg_etype[7:0]);
    kept = (n > 1500) ? 1500 : n;
    minp = tag ? 42 : 46;
    for (int k = 0; k < kept; k++) b.push_back(pat(k, seed));
    for (int k = kept; k < minp; k++) b.push_back(8'h00);
    c = 32'hFFFF_FFFF;
    foreach (b[j]) begin
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[j][k]) c = (c >> 1) ^ 32'hEDB8_8320;
        else c = c >> 1;
      end
    end
    c = ~c;
    foreach (b[j]) expq.push_back(b[j]);
    for (int k = 0; k < 4; k++) expq.push_back(c[8*k +: 8]);
  endtask

  task automatic send(input int n, input int seed, input bit bubbles);
    bit acc;
    for (int i = 0; i < n; i++) begin
      if (bubbles && (i % 7 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pat(i, seed);
      in_last  = (i == n - 1);
      do begin
        #4;
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames_done < target) @(negedge clk);
  endtask

  function automatic int first_bad(input int lo, input int hi);
    for (int k = lo; k < hi; k++) begin
      if (k >= fr.size() || fr[k] !== expq[k]) return k;
    end
    return -1;
  endfunction

  // Pops one received frame and compares it region by region with expq.
  task automatic verify(input string name, input bit tag, input bit exp_err);
    int len, hl, bad;
    bit e;
    hl  = tag ? 18 : 14;
    len = lenq.pop_front();
    e   = errq.pop_front();
    fr.delete();
    for (int k = 0; k < len; k++) fr.push_back(rxq.pop_front());
    chk(len == expq.size(), "R5", {name, " frame length"}, len, expq.size());
    bad = first_bad(0, 8);
    chk(bad < 0, "R2", {name, " preamble index"}, bad, -1);
    bad = first_bad(8, 8 + hl);
    chk(bad < 0, tag ? "R4" : "R3", {name, " header index"}, bad, -1);
    bad = first_bad(8 + hl, expq.size() - 4);
    chk(bad < 0, "R5", {name, " payload/pad index"}, bad, -1);
    bad = first_bad(expq.size() - 4, expq.size());
    chk(bad < 0, "R6", {name, " fcs index"}, bad, -1);
    chk(e == exp_err, "R7", {name, " err flag at end"}, e, exp_err);
  endtask

  task automatic run_one(input string name, input int n, input int seed, input bit tag,
                         input logic [2:0] pcp, input bit dei, input logic [11:0] vid,
                         input bit bubbles, input bit bp);
    int base;
    base  = frames_done;
    bp_en = bp;
    set_cfg(tag, pcp, dei, vid);
    build(n, seed, tag, pcp, dei, vid);
    send(n, seed, bubbles);
    wait_frames(base + 1);
    bp_en = 0;
    verify(name, tag, n > 1500);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    chk(out_err == 1'b0, "R1", "out_err after reset", out_err, 0);
  endtask

  task automatic t_short_frames;
    run_one("R5 untagged 10B", 10, 1, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
    run_one("R4 tagged 5B pcp7 vid2", 5, 2, 1'b1, 3'd7, 1'b0, 12'd2, 1'b0, 1'b0);
    run_one("R4 tagged 1B pcp5 dei1", 1, 3, 1'b1, 3'd5, 1'b1, 12'hABC, 1'b0, 1'b0);
  endtask

  task automatic t_boundaries;
    run_one("R5 untagged 46B", 46, 4, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
    run_one("R5 tagged 42B", 42, 5, 1'b1, 3'd7, 1'b0, 12'd2, 1'b0, 1'b0);
    run_one("R5 untagged 45B", 45, 6, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
    run_one("R6 untagged 60B", 60, 7, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
  endtask

  task automatic t_flow;
    hold_bad = 0;
    run_one("R9 untagged 30B stalls", 30, 8, 1'b0, 3'd0, 1'b0, 12'd0, 1'b1, 1'b1);
    run_one("R9 tagged 100B stalls", 100, 9, 1'b1, 3'd3, 1'b0, 12'h123, 1'b1, 1'b1);
    chk(!hold_bad, "R9", "output held under backpressure", hold_bad, 0);
  endtask

  task automatic t_truncate;
    run_one("R7 untagged 1503B", 1503, 10, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
    run_one("R7 untagged 1500B", 1500, 11, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0, 1'b0);
  endtask

  task automatic t_gap;
    int base;
    logic [7:0] expa[$];
    base = frames_done;
    gap_rdy_bad = 0;
    set_cfg(1'b0, 3'd0, 1'b0, 12'd0);
    send(10, 12, 1'b0);
    send(50, 13, 1'b0);
    wait_frames(base + 2);
    chk(last_gap == 12, "R8", "idle cycles between frames", last_gap, 12);
    chk(!gap_rdy_bad, "R8", "in_ready low in gap", gap_rdy_bad, 0);
    build(10, 12, 1'b0, 3'd0, 1'b0, 12'd0);
    verify("R8 first", 1'b0, 1'b0);
    build(50, 13, 1'b0, 3'd0, 1'b0, 12'd0);
    verify("R8 second", 1'b0, 1'b0);
    expa.delete();
  endtask

  task automatic t_cfg_latch;
    int base;
    base = frames_done;
    set_cfg(1'b1, 3'd7, 1'b0, 12'd2);
    build(20, 14, 1'b1, 3'd7, 1'b0, 12'd2);
    fork
      send(20, 14, 1'b0);
      begin
        wait (in_ready === 1'b1);
        @(negedge clk);
        cfg_tag_en = 1'b0;
        cfg_vid    = 12'h777;
        cfg_dst    = 48'hFFFF_FFFF_FFFF;
      end
    join
    wait_frames(base + 1);
    verify("R10 cfg change mid-frame", 1'b1, 1'b0);
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, -1);
    finish_up();
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_last = 1'b0;
    in_data = 8'h00;
    out_ready = 1'b1;
    set_cfg(1'b0, 3'd0, 1'b0, 12'd0);
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_short_frames();
    t_boundaries();
    t_flow();
    t_truncate();
    t_gap();
    t_cfg_latch();
    repeat (20) @(negedge clk);
    finish_up();
  end

endmodule